// File: doc/BRIEF.md
# Parallel-Load Serial-Drain Transform Output Stage

This block sits at the back end of a 64-point transform built from two ranks of 8-point units. The second rank delivers its results one octet at a time: eight complex samples per load, on eight consecutive cycles. The stage writes lane i of every octet straight into position 8i of a 57-entry complex shift register through fixed taps. The register drops by one position on every clock. Because each octet is loaded one cycle after the previous one, the eight interleaved octets leave position 0 in natural index order, one complex sample per cycle, with no output multiplexer.

A frame counter starts when the first octet of a frame is loaded. It raises a valid flag for exactly 64 cycles, one for each output sample. A new frame may begin on the cycle that carries the last sample of the previous frame, so frames can stream back to back. The frame's mode is captured together with its first octet. In inverse mode, every outgoing sample has its real and imaginary parts exchanged and is then divided by 64 with a sign-preserving right shift. Because the matching swap is applied at the transform input, a forward transform core can then deliver an inverse transform.

Top module: `pis_out_stage`

## Requirements
- R1: While reset is asserted, and after its release until the first frame, `out_valid` is 0 and both output words are 0.
- R2: A cycle that carries `ld_first` (with `ld_vld`) makes `out_valid` high from the next clock edge on. Without a new `ld_first`, it stays high for exactly 64 cycles and then falls.
- R3: Octet k (k = 0..7) is the load presented k cycles after `ld_first`. Lane i of `ld_re`/`ld_im` (bits [16i+15:16i]) holds the sample with index 8i+k. During the n-th valid cycle (n = 0..63), the outputs carry the sample with index n.
- R4: When the captured mode is 0 (forward), `dout_re`/`dout_im` equal the loaded real and imaginary words unchanged.
- R5: When the captured mode is 1 (inverse), `dout_re` equals the loaded imaginary word and `dout_im` the loaded real word, each arithmetically shifted right by 6 with sign extension and the low bits dropped.
- R6: `mode` is sampled only in the `ld_first` cycle. Changes to `mode` during the rest of the frame have no effect on that frame's outputs.
- R7: A `ld_first` in the cycle that carries sample 63 of a running frame keeps `out_valid` high without a gap. The next valid cycle carries sample 0 of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_vld | input | 1 | Octet load strobe |
| ld_first | input | 1 | Marks octet 0 of a frame; starts framing |
| mode | input | 1 | 0 forward, 1 inverse (swap and scale by 1/64) |
| ld_re | input | 128 | Real parts of eight lanes, lane i at bits [16i+15:16i] |
| ld_im | input | 128 | Imaginary parts of eight lanes, same layout |
| out_valid | output | 1 | High while a frame sample is on the outputs |
| dout_re | output | 16 | Serial real output |
| dout_im | output | 16 | Serial imaginary output |

## Verification
The assertions assume the following about the inputs: the eight octets of a frame arrive on consecutive cycles, `ld_first` always comes with `ld_vld`, and a new frame starts only when the stage is idle or on its last sample. A load outside this pattern would break the natural-order interleave, so no property is stated for it. The stimulus drives every frame as one unbroken eight-cycle burst. It starts the next frame either after the previous one has drained or exactly 64 cycles after it. It toggles `mode` only inside the octets that follow the first one.

// File: rtl/pis_pkg.sv
package pis_pkg;

   typedef enum logic {
      XF_FWD = 1'b0,
      XF_INV = 1'b1
   } xf_mode_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pis_tap_bank.sv
module pis_tap_bank #(
   parameter int DATA_W = 16,
   parameter int RADIX  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_vld,
   input  logic [RADIX*DATA_W-1:0] ld_lanes,
   output logic [DATA_W-1:0]       head
);
   localparam int DEPTH  = RADIX * (RADIX - 1) + 1;
   localparam int SR_W   = DEPTH * DATA_W;
   localparam int STRIDE = RADIX * DATA_W;

   logic [SR_W-1:0] sr_q;
   logic [SR_W-1:0] shifted;
   logic [SR_W-1:0] sr_d;

   // every position takes the one above; the top fills with zero
   assign shifted = {{DATA_W{1'b0}}, sr_q[SR_W-1:DATA_W]};

   always_comb begin
      sr_d = shifted;
      if (ld_vld) begin
         for (int i = 0; i < RADIX; i++) begin
            sr_d[i*STRIDE +: DATA_W] = ld_lanes[i*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
   end

   assign head = sr_q[DATA_W-1:0];

endmodule

// File: rtl/pis_frame_ctr.sv
module pis_frame_ctr #(
   parameter int N_PTS = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_first,
   input  logic                     mode,
   output logic                     frm_valid,
   output logic [$clog2(N_PTS)-1:0] frm_cnt,
   output logic                     mode_q
);
   localparam int CNT_W = $clog2(N_PTS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_PTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frm_valid <= 1'b0;
         frm_cnt   <= '0;
         mode_q    <= 1'b0;
      end else if (ld_first) begin
         frm_valid <= 1'b1;
         frm_cnt   <= '0;
         mode_q    <= mode;
      end else if (frm_valid) begin
         if (frm_cnt == LAST) begin
            frm_valid <= 1'b0;
            frm_cnt   <= '0;
         end else begin
            frm_cnt <= frm_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pis_post_xform.sv
module pis_post_xform #(
   parameter int DATA_W      = 16,
   parameter int SCALE_SH    = 6,
   parameter bit INV_SUPPORT = 1'b1
) (
   input  logic              inv,
   input  logic [DATA_W-1:0] in_re,
   input  logic [DATA_W-1:0] in_im,
   output logic [DATA_W-1:0] out_re,
   output logic [DATA_W-1:0] out_im
);
   generate
      if (INV_SUPPORT) begin : g_inv
         logic [DATA_W-1:0] sc_re;
         logic [DATA_W-1:0] sc_im;
         // swap first, then sign-extending right shift, low bits dropped
         assign sc_re  = DATA_W'($signed(in_im) >>> SCALE_SH);
         assign sc_im  = DATA_W'($signed(in_re) >>> SCALE_SH);
         assign out_re = inv ? sc_re : in_re;
         assign out_im = inv ? sc_im : in_im;
      end else begin : g_fwd_only
         logic unused_inv;
         assign unused_inv = inv;
         assign out_re     = in_re;
         assign out_im     = in_im;
      end
   endgenerate

endmodule

// File: rtl/pis_out_stage.sv
module pis_out_stage
   import pis_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int RADIX       = 8,
   parameter bit INV_SUPPORT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_vld,
   input  logic                    ld_first,
   input  logic                    mode,
   input  logic [RADIX*DATA_W-1:0] ld_re,
   input  logic [RADIX*DATA_W-1:0] ld_im,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       dout_re,
   output logic [DATA_W-1:0]       dout_im
);
   localparam int N_PTS    = RADIX * RADIX;
   localparam int CNT_W    = $clog2(N_PTS);
   localparam int SCALE_SH = $clog2(N_PTS);

   generate
      if (!is_pow2(RADIX)) begin : g_bad_radix
         $error("pis_out_stage: RADIX must be a power of two of at least 2");
      end
      if (DATA_W <= SCALE_SH) begin : g_bad_width
         $error("pis_out_stage: DATA_W must exceed the scaling shift");
      end
   endgenerate

   logic [DATA_W-1:0] head_re;
   logic [DATA_W-1:0] head_im;
   logic [CNT_W-1:0]  frm_cnt;
   logic              mode_q;
   xf_mode_e          mode_sel;

   pis_tap_bank #(.DATA_W(DATA_W), .RADIX(RADIX)) u_bank_re (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_vld   (ld_vld),
      .ld_lanes (ld_re),
      .head     (head_re)
   );

   pis_tap_bank #(.DATA_W(DATA_W), .RADIX(RADIX)) u_bank_im (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_vld   (ld_vld),
      .ld_lanes (ld_im),
      .head     (head_im)
   );

   pis_frame_ctr #(.N_PTS(N_PTS)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_first  (ld_first),
      .mode      (mode),
      .frm_valid (out_valid),
      .frm_cnt   (frm_cnt),
      .mode_q    (mode_q)
   );

   assign mode_sel = xf_mode_e'(mode_q);

   pis_post_xform #(
      .DATA_W      (DATA_W),
      .SCALE_SH    (SCALE_SH),
      .INV_SUPPORT (INV_SUPPORT)
   ) u_xform (
      .inv    (mode_sel == XF_INV),
      .in_re  (head_re),
      .in_im  (head_im),
      .out_re (dout_re),
      .out_im (dout_im)
   );

endmodule

// File: rtl/pis_out_stage_chk.sv
module pis_out_stage_chk #(
   parameter int DATA_W = 16,
   parameter int RADIX  = 8
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             ld_vld,
   input logic                             ld_first,
   input logic                             mode,
   input logic [DATA_W-1:0]                ld_re0,
   input logic [DATA_W-1:0]                ld_im0,
   input logic                             out_valid,
   input logic [DATA_W-1:0]                dout_re,
   input logic [DATA_W-1:0]                dout_im,
   input logic [$clog2(RADIX*RADIX)-1:0]   frm_cnt,
   input logic                             mode_q
);
   localparam int N_PTS = RADIX * RADIX;
   localparam int CNT_W = $clog2(N_PTS);
   localparam int SH    = $clog2(N_PTS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_PTS - 1);

   logic [CNT_W+1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          run_q <= '0;
      else if (ld_first)   run_q <= (CNT_W+2)'(1);
      else if (out_valid)  run_q <= run_q + 1'b1;
      else                 run_q <= '0;
   end

   // R1
   idle_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> frm_cnt == '0);

   // R2
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_first |=> out_valid && frm_cnt == '0);

   // R2
   valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && frm_cnt == LAST && !ld_first) |=> !out_valid);

   // R2
   valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (run_q >= (CNT_W+2)'(1) && run_q <= (CNT_W+2)'(N_PTS)));

   // R3
   burst_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_vld && !ld_first) |-> $past(ld_vld));

   // R3
   first_has_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_first |-> ld_vld);

   // R4
   fwd_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ld_first) && !$past(mode)) |->
         (dout_re == $past(ld_re0) && dout_im == $past(ld_im0)));

   // R5
   inv_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ld_first) && $past(mode)) |->
         (dout_re == DATA_W'($signed($past(ld_im0)) >>> SH) &&
          dout_im == DATA_W'($signed($past(ld_re0)) >>> SH)));

   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !ld_first) |=> $stable(mode_q));

   // R7
   back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && frm_cnt == LAST && ld_first) |=> (out_valid && frm_cnt == '0));

endmodule

bind pis_out_stage pis_out_stage_chk #(.DATA_W(DATA_W), .RADIX(RADIX)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_vld    (ld_vld),
   .ld_first  (ld_first),
   .mode      (mode),
   .ld_re0    (ld_re[DATA_W-1:0]),
   .ld_im0    (ld_im[DATA_W-1:0]),
   .out_valid (out_valid),
   .dout_re   (dout_re),
   .dout_im   (dout_im),
   .frm_cnt   (frm_cnt),
   .mode_q    (mode_q)
);

// File: tb/pis_out_stage_tb_top.sv
module pis_out_stage_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int RX = 8;
   localparam int NP = RX * RX;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_vld = 1'b0;
   logic ld_first = 1'b0;
   logic mode = 1'b0;
   logic [RX*DW-1:0] ld_re = '0;
   logic [RX*DW-1:0] ld_im = '0;
   logic out_valid;
   logic [DW-1:0] dout_re;
   logic [DW-1:0] dout_im;

   int n_vec = 0;
   int n_fail = 0;
   bit chk_en = 1'b0;

   logic signed [DW-1:0] pend_re [NP];
   logic signed [DW-1:0] pend_im [NP];
   bit    pend_mode;
   string pend_tag;

   logic signed [DW-1:0] cur_re [NP];
   logic signed [DW-1:0] cur_im [NP];
   bit    cur_mode;
   string cur_tag = "R2";
   bit    m_valid = 1'b0;
   int    m_idx = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pis_out_stage #(.DATA_W(DW), .RADIX(RX)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_vld    (ld_vld),
      .ld_first  (ld_first),
      .mode      (mode),
      .ld_re     (ld_re),
      .ld_im     (ld_im),
      .out_valid (out_valid),
      .dout_re   (dout_re),
      .dout_im   (dout_im)
   );

   // behavioural reference: a frame list and a sample index
   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 1'b0;
         m_idx   = 0;
      end else if (ld_first) begin
         for (int n = 0; n < NP; n++) begin
            cur_re[n] = pend_re[n];
            cur_im[n] = pend_im[n];
         end
         cur_mode = pend_mode;
         cur_tag  = pend_tag;
         m_valid  = 1'b1;
         m_idx    = 0;
      end else if (m_valid) begin
         if (m_idx == NP - 1) begin
            m_valid = 1'b0;
            m_idx   = 0;
         end else begin
            m_idx = m_idx + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (chk_en) begin
         logic signed [DW-1:0] e_re;
         logic signed [DW-1:0] e_im;
         n_vec++;
         if (out_valid !== m_valid) begin
            n_fail++;
            $display("FAIL R2 (%s) out_valid: actual %b expected %b", cur_tag, out_valid, m_valid);
         end
         if (m_valid) begin
            n_vec++;
            if (cur_mode) begin
               e_re = cur_im[m_idx] >>> 6;
               e_im = cur_re[m_idx] >>> 6;
            end else begin
               e_re = cur_re[m_idx];
               e_im = cur_im[m_idx];
            end
            if (dout_re !== e_re || dout_im !== e_im) begin
               n_fail++;
               $display("FAIL %s sample %0d: actual %h/%h expected %h/%h",
                        cur_tag, m_idx, dout_re, dout_im, e_re, e_im);
            end
         end
      end
   end

   task automatic make_frame(input int pat, input bit md, input string tag);
      for (int n = 0; n < NP; n++) begin
         case (pat)
            0: begin
               pend_re[n] = DW'(n * 97 - 3100);
               pend_im[n] = DW'(2000 - n * 61);
            end
            1: begin
               int tbl [8] = '{32767, -32768, -1, 63, 64, -64, -65, 0};
               pend_re[n] = DW'(tbl[n % 8]);
               pend_im[n] = DW'(tbl[(n + 3) % 8]);
            end
            default: begin
               pend_re[n] = DW'(n * 1021 + 7);
               pend_im[n] = ~DW'(n * 1021 + 7);
            end
         endcase
      end
      pend_mode = md;
      pend_tag  = tag;
   endtask

   // eight consecutive octets; optional mode toggling after the first
   task automatic send_frame(input bit md, input bit toggle);
      for (int k = 0; k < RX; k++) begin
         @(negedge clk);
         ld_vld   = 1'b1;
         ld_first = (k == 0);
         mode     = (k == 0) ? md : (toggle ? ((k % 2 == 1) ? ~md : md) : md);
         for (int i = 0; i < RX; i++) begin
            ld_re[i*DW +: DW] = pend_re[RX*i + k];
            ld_im[i*DW +: DW] = pend_im[RX*i + k];
         end
      end
      @(negedge clk);
      ld_vld   = 1'b0;
      ld_first = 1'b0;
      ld_re    = '0;
      ld_im    = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state, during and after reset
      repeat (3) @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0 || dout_re !== '0 || dout_im !== '0) begin
         n_fail++;
         $display("FAIL R1 in reset: actual %b %h %h expected 0 0000 0000", out_valid, dout_re, dout_im);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0 || dout_re !== '0 || dout_im !== '0) begin
         n_fail++;
         $display("FAIL R1 after reset: actual %b %h %h expected 0 0000 0000", out_valid, dout_re, dout_im);
      end
      chk_en = 1'b1;
      idle(2);

      // R3 R4: forward, ramp data
      make_frame(0, 1'b0, "R3 R4");
      send_frame(1'b0, 1'b0);
      idle(70);

      // R3 R5: inverse, extreme values
      make_frame(1, 1'b1, "R3 R5");
      send_frame(1'b1, 1'b0);
      idle(70);

      // R6: mode toggled during an inverse frame
      make_frame(2, 1'b1, "R6 inv");
      send_frame(1'b1, 1'b1);
      idle(70);

      // R6: mode toggled during a forward frame
      make_frame(1, 1'b0, "R6 fwd");
      send_frame(1'b0, 1'b1);
      idle(70);

      // R7: second frame starts on the last sample of the first
      make_frame(0, 1'b1, "R5 first");
      send_frame(1'b1, 1'b0);
      idle(NP - RX - 1);
      make_frame(2, 1'b0, "R7");
      send_frame(1'b0, 1'b0);
      idle(70);

      chk_en = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule